// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is a management-bus master for an Ethernet PHY. A host hands it one packed 32-bit frame word. The block then runs one complete register read or write on the two-wire management bus: a clock line (MDC) and a bidirectional data line split into `mdio_o`, `mdio_oe` and `mdio_i`. Storing the word into the data register is the only action that starts a transfer. When the transfer ends, a completion flag is raised in the event word.

Every transfer starts with a run of preamble ones. After the preamble, the 32 frame bits are shifted out MSB first. Frame bits 31:30 hold the start pattern 01. Bits 29:28 hold the opcode: 10 is a read and 01 is a write. Bits 27:23 are the PHY address, bits 22:18 the register address, bits 17:16 the turnaround pattern 10, and bits 15:0 the write data. On a read, the master releases the line from the second turnaround bit onward. The 16 bits the PHY returns land in the low half of the same data register.

MDC is derived from the system clock. Each MDC phase lasts `div` system clocks, where `div` is bits 6:1 of the speed word. A zero divider holds MDC low. The transfer engine only accepts frames while the management enable input is high.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: An accepted frame goes out as 32 ones followed by the 32 command bits, MSB first. One bit is presented per MDC period.
- R2: With divider D non-zero, each MDC phase lasts D clocks. `mdio_o` changes only on MDC falling edges. `busy` is high for exactly 128·D clocks.
- R3: For opcode 10 (read), `mdio_oe` is low for frame bit 16 and for all 16 data bits, that is, the last 17 bit periods. For any other opcode, `mdio_oe` is high for all 64 bit periods.
- R4: On a read, `mdio_i` is sampled on each MDC rising edge of the 16 data bits, MSB first. The result replaces bits 15:0 of the data register. Bits 31:16 keep the command value.
- R5: On a write, the data register holds the command word unchanged after completion.
- R6: Completion sets bit 23 of the event word. Writing 1 to bit 23 of the clear input clears it.
- R7: The divider is bits 6:1 of the speed word. While the divider is zero, MDC stays low and an accepted frame stalls until a non-zero divider is written.
- R8: A command written while `busy` is high is ignored. The data register and the frame in flight are unaffected.
- R9: A command written while `mii_en` is low is ignored and no transfer starts.
- R10: After reset, `busy`, `mdc` and `mdio_oe` are low, and the data register and event word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_en | input | 1 | Management interface enable |
| cmd_wr | input | 1 | Write strobe for the frame/data register |
| cmd_wdata | input | 32 | Frame word to store |
| spd_wr | input | 1 | Write strobe for the speed word |
| spd_wdata | input | 32 | Speed word; bits 6:1 are the divider |
| evt_clr_wr | input | 1 | Write strobe for event clear |
| evt_clr_data | input | 32 | Write-one-to-clear mask |
| data_rd | output | 32 | Frame/data register contents |
| evt_word | output | 32 | Event word; bit 23 is completion |
| busy | output | 1 | Transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench sweeps dividers 1 to 3 across reads and writes with several address and data patterns. A model PHY follows MDC edges and checks every bit.

A design with an off-by-one release point would show the wrong `mdio_oe` count around the turnaround. A design with the wrong sampling edge or bit order would return shifted or reversed read data. A miscounted divider would stretch or shrink `busy` away from 128·D.

Three cases are forced on purpose:
- a second command during a transfer, which a faulty design lets overwrite the register or restart the frame;
- a command with the enable low, which a faulty design starts anyway;
- a zero divider, which a faulty design lets run or finish.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int unsigned CMD_W   = 32;
  localparam int unsigned DAT_W   = 16;
  localparam int unsigned EVT_BIT = 23;
  localparam logic [1:0]  OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             term;

  always_comb begin
    term  = run && (div != '0) && (cnt_q >= div - 1'b1);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (div != '0) begin
      if (term) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_tk = term & ~mdc_q;
  assign fall_tk = term &  mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_frame_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  input  logic             rise_tk,
  input  logic             fall_tk,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             is_rd,
  output logic [DAT_W-1:0] rd_data,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int unsigned TOT     = PRE_LEN + CMD_W;
  localparam int unsigned IDX_W   = $clog2(TOT);
  localparam int unsigned REL_IDX = PRE_LEN + CMD_W - DAT_W - 1;
  localparam int unsigned DAT_IDX = PRE_LEN + CMD_W - DAT_W;
  localparam int unsigned LAST    = TOT - 1;

  logic [TOT-1:0]   sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic [DAT_W-1:0] rx_q, rx_d;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    rx_d   = rx_q;
    done   = busy_q && fall_tk && (idx_q == IDX_W'(LAST));
    if (start && !busy_q) begin
      sh_d   = {{PRE_LEN{1'b1}}, cmd};
      idx_d  = '0;
      busy_d = 1'b1;
      rd_d   = (cmd[29:28] == OP_READ);
      rx_d   = '0;
    end else if (busy_q) begin
      if (rise_tk && rd_q && (idx_q >= IDX_W'(DAT_IDX)))
        rx_d = {rx_q[DAT_W-2:0], mdio_i};
      if (fall_tk) begin
        if (done) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[TOT-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign rd_data = rx_q;
  assign mdio_o  = busy_q ? sh_q[TOT-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(REL_IDX)));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_frame_pkg::*;
#(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mii_en,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        spd_wr,
  input  logic [31:0] spd_wdata,
  input  logic        evt_clr_wr,
  input  logic [31:0] evt_clr_data,
  output logic [31:0] data_rd,
  output logic [31:0] evt_word,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [CMD_W-1:0] data_q, data_d;
  logic             evt_q, evt_d;
  logic [DIV_W-1:0] spd_q, spd_d;
  logic             accept, done, is_rd, rise_tk, fall_tk;
  logic [DAT_W-1:0] rd_data;

  assign accept = cmd_wr && mii_en && !busy;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(spd_q),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_sh (
    .clk(clk), .rst_n(rst_n), .start(accept), .cmd(cmd_wdata),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .done(done), .is_rd(is_rd), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_comb begin
    data_d = data_q;
    if (accept)
      data_d = cmd_wdata;
    else if (done && is_rd)
      data_d = {data_q[CMD_W-1:DAT_W], rd_data};
    evt_d = done || (evt_q && !(evt_clr_wr && evt_clr_data[EVT_BIT]));
    spd_d = spd_wr ? spd_wdata[DIV_W:1] : spd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      evt_q  <= 1'b0;
      spd_q  <= '0;
    end else begin
      data_q <= data_d;
      evt_q  <= evt_d;
      spd_q  <= spd_d;
    end
  end

  assign data_rd  = data_q;
  assign evt_word = 32'(evt_q) << EVT_BIT;
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mii_en,
  input logic             cmd_wr,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [31:0]      evt_word,
  input logic [DIV_W-1:0] div
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  p_data_stable_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));
  p_end_sets_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_word[23]);
  p_zero_div_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && $past(div) == '0 && busy) |-> !mdc);
  p_no_start_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !mii_en) |=> !busy);
endmodule

bind mdio_frame_ctrl mdio_frame_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mii_en(mii_en), .cmd_wr(cmd_wr), .busy(busy),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .evt_word(evt_word),
  .div(spd_q)
);

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mii_en = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        spd_wr = 1'b0;
  logic [31:0] spd_wdata = '0;
  logic        evt_clr_wr = 1'b0;
  logic [31:0] evt_clr_data = '0;
  logic [31:0] data_rd, evt_word;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  mdio_frame_ctrl u_mdio_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .mii_en(mii_en), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .spd_wr(spd_wr), .spd_wdata(spd_wdata),
    .evt_clr_wr(evt_clr_wr), .evt_clr_data(evt_clr_data),
    .data_rd(data_rd), .evt_word(evt_word), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic set_div(input int d);
    @(negedge clk); spd_wr = 1'b1; spd_wdata = 32'(d) << 1;
    @(negedge clk); spd_wr = 1'b0;
  endtask

  task automatic clr_evt();
    @(negedge clk); evt_clr_wr = 1'b1; evt_clr_data = 32'h0080_0000;
    @(negedge clk); evt_clr_wr = 1'b0; evt_clr_data = '0;
  endtask

  // Issue cmd and act as a PHY until busy drops; checks R1..R6.
  task automatic run_frame(input logic [31:0] cmd, input int d, input logic [15:0] phy,
                           input bit extra_cmd);
    logic [63:0] full;
    int rises, falls, nbusy, bad_bits, oe_low, bad_oe, mdc_hi_run, bad_phase;
    bit prev, rd;
    full = {32'hFFFF_FFFF, cmd};
    rd = (cmd[29:28] == 2'b10);
    rises = 0; falls = 0; nbusy = 0; bad_bits = 0; oe_low = 0; bad_oe = 0;
    mdc_hi_run = 0; bad_phase = 0; prev = 1'b0;
    mdio_i = 1'b1;
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = cmd;
    @(negedge clk); cmd_wr = 1'b0;
    while (busy && nbusy < 2000) begin
      nbusy++;
      if (extra_cmd && nbusy == 20) begin
        cmd_wr = 1'b1; cmd_wdata = 32'h1234_5678;
      end else begin
        cmd_wr = 1'b0;
      end
      if (mdc) mdc_hi_run++;
      if (mdc && !prev) begin
        if (rises < 64) begin
          if (rd && rises >= 47) begin
            if (mdio_oe) bad_oe++;
          end else begin
            if (!mdio_oe) bad_oe++;
            if (mdio_o !== full[63-rises]) bad_bits++;
          end
          if (!mdio_oe) oe_low++;
        end
        rises++;
      end
      if (!mdc && prev) begin
        if (mdc_hi_run != d) bad_phase++;
        mdc_hi_run = 0;
        falls++;
        if (falls >= 48 && falls <= 63) mdio_i = phy[63-falls];
        else mdio_i = 1'b1;
      end
      prev = mdc;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    chk(bad_bits == 0 && rises == 64, "R1 frame bits", bad_bits, 0);
    chk(nbusy == 128*d, "R2 busy length", nbusy, 128*d);
    chk(bad_phase == 0, "R2 mdc phase", bad_phase, 0);
    chk(bad_oe == 0 && oe_low == (rd ? 17 : 0), "R3 oe release", oe_low, rd ? 17 : 0);
    if (rd) chk(data_rd == {cmd[31:16], phy}, "R4 read data", data_rd, {cmd[31:16], phy});
    else    chk(data_rd == cmd, "R5 write keeps cmd", data_rd, cmd);
    if (extra_cmd) chk(data_rd[31:16] == cmd[31:16], "R8 busy cmd ignored", data_rd, cmd);
    chk(evt_word == 32'h0080_0000, "R6 event set", evt_word, 32'h0080_0000);
    clr_evt();
    chk(evt_word == 32'h0, "R6 event clear", evt_word, 0);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !mdc && !mdio_oe, "R10 idle outputs", {busy, mdc, mdio_oe}, 0);
    chk(data_rd == 0 && evt_word == 0, "R10 regs zero", data_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 disabled
    set_div(1);
    mii_en = 1'b0;
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = mk(2'b10, 5'd1, 5'd2, 16'h0);
    @(negedge clk); cmd_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && data_rd == 0, "R9 disabled ignored", {busy, data_rd}, 0);
    mii_en = 1'b1;
    // Sweep
    for (int d = 1; d <= 3; d++) begin
      set_div(d);
      for (int k = 0; k < 2; k++) begin
        logic [4:0] pa, ra;
        logic [15:0] wd, pd;
        pa = k ? 5'h1F : 5'h05; ra = k ? 5'h0A : 5'h11;
        wd = k ? 16'hA5C3 : 16'h0001; pd = k ? 16'h8001 : 16'h3C96 ^ 16'(d);
        run_frame(mk(2'b10, pa, ra, 16'hFFFF), d, pd, 1'b0);
        run_frame(mk(2'b01, pa, ra, wd), d, 16'h0, 1'b0);
      end
    end
    // R8 command while busy
    set_div(2);
    run_frame(mk(2'b10, 5'h03, 5'h04, 16'h0), 2, 16'h5AA5, 1'b1);
    // R7 zero divider stalls
    set_div(0);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = mk(2'b01, 5'h02, 5'h03, 16'hBEEF);
    @(negedge clk); cmd_wr = 1'b0;
    begin
      int hi;
      hi = 0;
      repeat (60) begin @(negedge clk); if (mdc) hi++; end
      chk(hi == 0 && busy, "R7 zero divider holds", {hi, busy}, 1);
    end
    set_div(1);
    begin
      int n;
      n = 0;
      while (busy && n < 1000) begin @(negedge clk); n++; end
      chk(!busy && data_rd == mk(2'b01, 5'h02, 5'h03, 16'hBEEF), "R7 resumes", data_rd,
          mk(2'b01, 5'h02, 5'h03, 16'hBEEF));
    end
    finish_up();
  end
endmodule